// File: doc/BRIEF.md
# Single-Wire Battery-Gauge Bus Master

This block is a byte-register controller that talks to one slave device, such as a battery monitor, over a single open-drain data line. Software can ask for three operations: a break pulse that resets the bus, a transmit of one byte, and a receive of one byte. It picks the operation with two qualifier bits and starts it with a start bit. The start bit clears by itself when the operation ends, and the matching completion flag is latched in an interrupt status register. Reading that register clears its flags.

Each bit goes out and comes in least significant bit first. For a transmit, every bit cell begins with the master pulling the line low. The low time is short for a 1 and long for a 0, and the line is then released until the cell ends. For a receive, the master keeps the line released. It waits for the slave to pull the line low, then samples the line a fixed time after that falling edge. If the slave does not respond within a configurable window, the receive is abandoned. All timing is given as parameters counted in system clock cycles. A soft reset returns every register to its default and reports when it has finished. A revision register gives the hardware version, and an interrupt output is provided.

Sequencer states: `S_IDLE`, `S_BRK_LOW`, `S_BRK_REC`, `S_WR_BIT`, `S_RD_WAIT`, `S_RD_BIT`. Transitions:
- IDLE→BRK_LOW when a break starts. BRK_LOW→BRK_REC after `T_BRK` cycles. BRK_REC→IDLE after `T_BRK_REC` cycles.
- IDLE→WR_BIT when a transmit starts. WR_BIT→WR_BIT at the end of each `T_CELL` cell. WR_BIT→IDLE after the eighth cell.
- IDLE→RD_WAIT when a receive starts. RD_WAIT→RD_BIT on a falling edge from the slave. RD_WAIT→IDLE after `T_RXWAIT` cycles with no edge (timeout).
- RD_BIT→RD_WAIT at the end of each cell. RD_BIT→IDLE after the eighth cell.
- Any state→IDLE on a soft reset.

Top module: `swire_master`

## Requirements
- R1: Reading offset 0x00 returns the major revision in bits 7:4 and the minor revision in bits 3:0.
- R2: Writing control (offset 0x0C) with GO (bit 4) = 1, INIT (bit 2) = 0 and DIR (bit 1) = 0 sends the byte held at offset 0x04, LSB first. Each bit cell lasts `T_CELL` cycles and begins with the line pulled low for `T_LOW1` cycles for a 1 or `T_LOW0` cycles for a 0. Afterwards transmit-complete (status bit 2) is set and GO reads 0.
- R3: GO together with INIT pulls the line low for `T_BRK` cycles and then releases it for `T_BRK_REC` cycles. Afterwards the timeout flag (status bit 0) is set and both INIT and GO read 0.
- R4: GO with DIR = 1 receives eight bits, LSB first. Each bit is taken as the line level `T_SAMPLE` cycles after a falling edge from the slave is seen, where low means 0. The byte is stored at offset 0x08, receive-complete (status bit 1) is set and GO reads 0.
- R5: If no falling edge is seen within `T_RXWAIT` cycles while waiting for a receive bit, the receive ends. The timeout flag (bit 0) is set, receive-complete stays 0 and GO reads 0.
- R6: Reading interrupt status (offset 0x10) returns the latched flags and clears them all.
- R7: `irq` is high exactly when interrupt enable (control bit 6) is 1 and at least one status flag is set.
- R8: A write to control while GO is 1 does not change GO, INIT or DIR and does not start a second operation.
- R9: Writing 1 to bit 1 of offset 0x14 returns all registers to their defaults and aborts any operation. During the `RST_CYC` cycles that follow, bit 0 of offset 0x18 reads 0 and bit 1 of offset 0x14 reads 1. After that, bit 0 of offset 0x18 reads 1.
- R10: `line_pull` only ever asks for the line to be driven low, and it is 0 whenever no operation is in progress. `line_in` passes through a two-flop synchronizer before it is used.
- R11: After reset, control, status, data and configuration read 0, reset-done reads 1, and `irq` and `line_pull` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| line_pull | output | 1 | 1 = drive the data line low, 0 = release it |
| line_in | input | 1 | Level sensed on the data line |

## Verification
The hardest situation to reach is a receive that depends on when the slave pulls the line. The sampling point is counted from the synchronized edge, not from the raw one, so a slave model in the bench pulls the open-drain line short or long at a fixed spacing while the master holds it released. The bench then compares the assembled byte. A start command sent during an operation that is still in progress is also hard to reach. The bench writes the read and break qualifiers in the middle of a transmit. It then checks through the scoreboard of low-pulse widths that no extra pulses appear, and checks that the control readback kept its earlier bits.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BRK_LOW,
        S_BRK_REC,
        S_WR_BIT,
        S_RD_WAIT,
        S_RD_BIT
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_TX,
        OP_RX,
        OP_BRK
    } seq_op_t;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_REV   = 5'h00;
    localparam logic [ADDR_W-1:0] A_TXD   = 5'h04;
    localparam logic [ADDR_W-1:0] A_RXD   = 5'h08;
    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_INT   = 5'h10;
    localparam logic [ADDR_W-1:0] A_SCFG  = 5'h14;
    localparam logic [ADDR_W-1:0] A_SSTAT = 5'h18;

    localparam int CB_IEN  = 6;
    localparam int CB_CKEN = 5;
    localparam int CB_GO   = 4;
    localparam int CB_INIT = 2;
    localparam int CB_DIR  = 1;
    localparam int CB_MODE = 0;

    localparam int IB_TX = 2;
    localparam int IB_RX = 1;
    localparam int IB_TO = 0;

    localparam int SB_SRST = 1;
    localparam int SB_IDLE = 0;

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= RST_VAL;
                end else begin
                    chain[g] <= (g == 0) ? d : chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/swire_seq.sv
module swire_seq
    import swire_pkg::*;
#(
    parameter int T_BRK     = 19000,
    parameter int T_BRK_REC = 4000,
    parameter int T_CELL    = 19000,
    parameter int T_LOW1    = 4000,
    parameter int T_LOW0    = 12000,
    parameter int T_SAMPLE  = 6500,
    parameter int T_RXWAIT  = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       start,
    input  seq_op_t    op,
    input  logic [7:0] tx_byte,
    input  logic       line_s,
    output logic       drive_low,
    output logic       busy,
    output logic       done_tx,
    output logic       done_rx,
    output logic       done_to,
    output logic [7:0] rx_byte
);

    localparam int CW = $clog2(T_BRK + T_BRK_REC + T_CELL + T_RXWAIT + 2);

    localparam logic [CW-1:0] C_BRK  = CW'(T_BRK - 1);
    localparam logic [CW-1:0] C_REC  = CW'(T_BRK_REC - 1);
    localparam logic [CW-1:0] C_CELL = CW'(T_CELL - 1);
    localparam logic [CW-1:0] C_SMP  = CW'(T_SAMPLE - 1);
    localparam logic [CW-1:0] C_WAIT = CW'(T_RXWAIT - 1);
    localparam logic [CW-1:0] C_LOW1 = CW'(T_LOW1);
    localparam logic [CW-1:0] C_LOW0 = CW'(T_LOW0);

    seq_state_t      state;
    logic [CW-1:0]   cnt;
    logic [2:0]      bitn;
    logic [7:0]      shreg;
    logic            line_q;
    logic            fall;

    assign fall = line_q & ~line_s;

    // State register with counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            line_q <= 1'b1;
        end else begin
            line_q <= line_s;
            if (clr) begin
                state <= S_IDLE;
                cnt   <= '0;
                bitn  <= '0;
                shreg <= '0;
            end else begin
                unique case (state)
                    S_IDLE: begin
                        cnt  <= '0;
                        bitn <= '0;
                        if (start) begin
                            unique case (op)
                                OP_BRK:  state <= S_BRK_LOW;
                                OP_RX:   state <= S_RD_WAIT;
                                default: begin
                                    state <= S_WR_BIT;
                                    shreg <= tx_byte;
                                end
                            endcase
                        end
                    end
                    S_BRK_LOW: begin
                        if (cnt == C_BRK) begin
                            cnt   <= '0;
                            state <= S_BRK_REC;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_BRK_REC: begin
                        if (cnt == C_REC) begin
                            cnt   <= '0;
                            state <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_WR_BIT: begin
                        if (cnt == C_CELL) begin
                            cnt   <= '0;
                            shreg <= {1'b0, shreg[7:1]};
                            bitn  <= bitn + 1'b1;
                            if (bitn == 3'd7) state <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_RD_WAIT: begin
                        if (fall) begin
                            cnt   <= '0;
                            state <= S_RD_BIT;
                        end else if (cnt == C_WAIT) begin
                            cnt   <= '0;
                            state <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_RD_BIT: begin
                        if (cnt == C_SMP) shreg <= {line_s, shreg[7:1]};
                        if (cnt == C_CELL) begin
                            cnt   <= '0;
                            bitn  <= bitn + 1'b1;
                            state <= (bitn == 3'd7) ? S_IDLE : S_RD_WAIT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        drive_low = 1'b0;
        done_tx   = 1'b0;
        done_rx   = 1'b0;
        done_to   = 1'b0;
        if (state == S_BRK_LOW) drive_low = 1'b1;
        if (state == S_WR_BIT) drive_low = (cnt < (shreg[0] ? C_LOW1 : C_LOW0));
        if (!clr) begin
            done_tx = (state == S_WR_BIT) && (cnt == C_CELL) && (bitn == 3'd7);
            done_rx = (state == S_RD_BIT) && (cnt == C_CELL) && (bitn == 3'd7);
            done_to = ((state == S_BRK_REC) && (cnt == C_REC)) ||
                      ((state == S_RD_WAIT) && !fall && (cnt == C_WAIT));
        end
    end

    assign busy    = (state != S_IDLE);
    assign rx_byte = shreg;

    p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !drive_low);

    p_start_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == S_IDLE));

endmodule

// File: rtl/swire_master.sv
module swire_master
    import swire_pkg::*;
#(
    parameter logic [3:0] REV_MAJOR   = 4'd1,
    parameter logic [3:0] REV_MINOR   = 4'd0,
    parameter int         T_BRK       = 19000,
    parameter int         T_BRK_REC   = 4000,
    parameter int         T_CELL      = 19000,
    parameter int         T_LOW1      = 4000,
    parameter int         T_LOW0      = 12000,
    parameter int         T_SAMPLE    = 6500,
    parameter int         T_RXWAIT    = 50000,
    parameter int         RST_CYC     = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              line_pull,
    input  logic              line_in
);

    localparam int RW = $clog2(RST_CYC + 1);
    localparam logic [RW-1:0] C_RST = RW'(RST_CYC);

    logic [7:0]    txd, rxd;
    logic          ien, cken, go, init, dir, mode, autoidle;
    logic [2:0]    flags;
    logic [RW-1:0] srst_cnt;
    logic          srst_active, srst_req;
    logic          wr, rd, launch;
    seq_op_t       launch_op;
    logic          line_s;
    logic          seq_busy, seq_done_tx, seq_done_rx, seq_done_to, seq_done_any;
    logic [7:0]    seq_rx;

    assign srst_active  = (srst_cnt != '0);
    assign wr           = reg_sel & reg_wr & ~srst_active;
    assign rd           = reg_sel & ~reg_wr;
    assign srst_req     = wr && (reg_addr == A_SCFG) && reg_wdata[SB_SRST];
    assign launch       = wr && (reg_addr == A_CTRL) && reg_wdata[CB_GO] && !go;
    assign launch_op    = reg_wdata[CB_INIT] ? OP_BRK : (reg_wdata[CB_DIR] ? OP_RX : OP_TX);
    assign seq_done_any = seq_done_tx | seq_done_rx | seq_done_to;

    swire_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    swire_seq #(
        .T_BRK     (T_BRK),
        .T_BRK_REC (T_BRK_REC),
        .T_CELL    (T_CELL),
        .T_LOW1    (T_LOW1),
        .T_LOW0    (T_LOW0),
        .T_SAMPLE  (T_SAMPLE),
        .T_RXWAIT  (T_RXWAIT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst_req | srst_active),
        .start     (launch),
        .op        (launch_op),
        .tx_byte   (txd),
        .line_s    (line_s),
        .drive_low (line_pull),
        .busy      (seq_busy),
        .done_tx   (seq_done_tx),
        .done_rx   (seq_done_rx),
        .done_to   (seq_done_to),
        .rx_byte   (seq_rx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd <= '0; rxd <= '0; flags <= '0;
            ien <= 1'b0; cken <= 1'b0; go <= 1'b0; init <= 1'b0;
            dir <= 1'b0; mode <= 1'b0; autoidle <= 1'b0;
            srst_cnt <= '0;
        end else if (srst_req || srst_active) begin
            txd <= '0; rxd <= '0; flags <= '0;
            ien <= 1'b0; cken <= 1'b0; go <= 1'b0; init <= 1'b0;
            dir <= 1'b0; mode <= 1'b0; autoidle <= 1'b0;
            srst_cnt <= srst_req ? C_RST : srst_cnt - 1'b1;
        end else begin
            if (wr && reg_addr == A_TXD) txd <= reg_wdata;
            if (wr && reg_addr == A_SCFG) autoidle <= reg_wdata[SB_IDLE];
            if (wr && reg_addr == A_CTRL) begin
                ien  <= reg_wdata[CB_IEN];
                cken <= reg_wdata[CB_CKEN];
                mode <= reg_wdata[CB_MODE];
                if (!go) begin
                    go   <= reg_wdata[CB_GO];
                    init <= reg_wdata[CB_INIT];
                    dir  <= reg_wdata[CB_DIR];
                end
            end
            if (seq_done_any) begin
                go   <= 1'b0;
                init <= 1'b0;
            end
            if (seq_done_rx) rxd <= seq_rx;
            flags <= (flags & ~{3{rd && (reg_addr == A_INT)}}) |
                     {seq_done_tx, seq_done_rx, seq_done_to};
        end
    end

    always_comb begin
        case (reg_addr)
            A_REV:   reg_rdata = {REV_MAJOR, REV_MINOR};
            A_TXD:   reg_rdata = txd;
            A_RXD:   reg_rdata = rxd;
            A_CTRL:  reg_rdata = {1'b0, ien, cken, go, 1'b0, init, dir, mode};
            A_INT:   reg_rdata = {5'b0, flags};
            A_SCFG:  reg_rdata = {6'b0, srst_active, autoidle};
            A_SSTAT: reg_rdata = {7'b0, ~srst_active};
            default: reg_rdata = 8'h00;
        endcase
    end

    assign irq = ien & (|flags);

    p_go_tracks_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go == seq_busy);

    p_done_clears_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_any |=> !go);

    p_tx_flag_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_tx |=> flags[IB_TX]);

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && reg_addr == A_INT && !seq_done_any && !srst_req) |=> (flags == 3'b000));

    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_active |-> (!go && flags == 3'b000 && !line_pull));

endmodule

// File: tb/test_swire_master.sv
module test_swire_master;

    localparam int P_BRK = 40, P_REC = 10, P_CELL = 40, P_LOW1 = 8, P_LOW0 = 24;
    localparam int P_SMP = 14, P_WAIT = 60, P_RST = 6;

    typedef struct {
        int    w;
        string tag;
    } exp_t;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       irq, line_pull, line_in;
    logic       slave_low = 1'b0;
    int         tests = 0, fails = 0;
    bit         done_flag = 1'b0;
    exp_t       exp_q[$];

    assign line_in = ~(line_pull | slave_low);

    always #2 clk = ~clk;

    swire_master #(
        .REV_MAJOR(4'h2), .REV_MINOR(4'h7),
        .T_BRK(P_BRK), .T_BRK_REC(P_REC), .T_CELL(P_CELL), .T_LOW1(P_LOW1),
        .T_LOW0(P_LOW0), .T_SAMPLE(P_SMP), .T_RXWAIT(P_WAIT), .RST_CYC(P_RST),
        .SYNC_STAGES(2)
    ) i_swire_master (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .line_pull(line_pull), .line_in(line_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic expect_read(input logic [4:0] a, input logic [7:0] e, input string tag);
        logic [7:0] v;
        bus_read(a, v);
        check(v === e, tag, v, e);
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 3000; i++) begin
            bus_read(5'h0C, v);
            if (!v[4]) break;
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input string tag);
        for (int i = 0; i < 8; i++) exp_q.push_back('{b[i] ? P_LOW1 : P_LOW0, tag});
    endtask

    task automatic slave_send(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            int w;
            w = b[i] ? 5 : 28;
            repeat (6) @(negedge clk);
            slave_low = 1'b1;
            repeat (w) @(negedge clk);
            slave_low = 1'b0;
            repeat (48 - 6 - w) @(negedge clk);
        end
    endtask

    // Monitor: measures each low pulse and compares with the scoreboard
    initial begin
        int run;
        run = 0;
        forever begin
            @(negedge clk);
            if (line_pull) begin
                run++;
            end else if (run > 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R3 unexpected low pulse", run, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(run == e.w, e.tag, run, e.w);
                end
                run = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11 reset state
        check(line_pull == 1'b0, "R11 line released", line_pull, 0);
        check(irq == 1'b0, "R11 irq low", irq, 0);
        expect_read(5'h0C, 8'h00, "R11 control default");
        expect_read(5'h10, 8'h00, "R11 status default");
        expect_read(5'h14, 8'h00, "R11 config default");
        expect_read(5'h18, 8'h01, "R11 reset done");

        // R1 revision
        expect_read(5'h00, 8'h27, "R1 revision");

        // R2 transmit 0xA5
        bus_write(5'h04, 8'hA5);
        push_byte(8'hA5, "R2 tx 0xA5 bit width");
        bus_write(5'h0C, 8'h10);
        wait_idle();
        expect_read(5'h10, 8'h04, "R2 tx complete flag");
        expect_read(5'h10, 8'h00, "R6 flags cleared by read");
        check(line_pull == 1'b0, "R10 released after tx", line_pull, 0);

        // R8 transmit 0x0F with extra start writes while busy
        bus_write(5'h04, 8'h0F);
        push_byte(8'h0F, "R8 tx 0x0F bit width");
        bus_write(5'h0C, 8'h10);
        repeat (20) @(negedge clk);
        bus_write(5'h0C, 8'h12);
        bus_write(5'h0C, 8'h14);
        expect_read(5'h0C, 8'h10, "R8 control unchanged while busy");
        wait_idle();
        expect_read(5'h0C, 8'h00, "R8 dir/init not taken");
        expect_read(5'h10, 8'h04, "R8 only tx flag");

        // R3 break
        exp_q.push_back('{P_BRK, "R3 break low width"});
        bus_write(5'h0C, 8'h14);
        repeat (P_BRK + 2) @(negedge clk);
        expect_read(5'h0C, 8'h14, "R3 go/init held in recovery");
        wait_idle();
        expect_read(5'h0C, 8'h00, "R3 go and init cleared");
        expect_read(5'h10, 8'h01, "R3 timeout flag");

        // R4 receive with slave model
        bus_write(5'h0C, 8'h12);
        slave_send(8'h3C);
        wait_idle();
        expect_read(5'h08, 8'h3C, "R4 rx byte 0x3C");
        expect_read(5'h10, 8'h02, "R4 rx complete flag");
        bus_write(5'h0C, 8'h12);
        slave_send(8'h81);
        wait_idle();
        expect_read(5'h08, 8'h81, "R4 rx byte 0x81");
        check(line_pull == 1'b0, "R10 master never pulls on receive", line_pull, 0);

        // R5 receive with silent slave
        expect_read(5'h10, 8'h02, "R6 flags before timeout case");
        bus_write(5'h0C, 8'h12);
        repeat (P_WAIT + 4) @(negedge clk);
        expect_read(5'h0C, 8'h02, "R5 go cleared after window");
        expect_read(5'h10, 8'h01, "R5 timeout flag only");
        expect_read(5'h08, 8'h81, "R5 rx data kept");

        // R7 interrupt gating
        bus_write(5'h04, 8'h01);
        push_byte(8'h01, "R7 tx 0x01 bit width");
        bus_write(5'h0C, 8'h50);
        check(irq == 1'b0, "R7 irq low while busy", irq, 0);
        wait_idle();
        check(irq == 1'b1, "R7 irq on with enable", irq, 1);
        expect_read(5'h10, 8'h04, "R7 tx flag");
        check(irq == 1'b0, "R7 irq off after read", irq, 0);
        exp_q.push_back('{P_BRK, "R7 break low width"});
        bus_write(5'h0C, 8'h14);
        wait_idle();
        check(irq == 1'b0, "R7 irq gated by enable", irq, 0);
        expect_read(5'h10, 8'h01, "R7 timeout flag pending");

        // R9 soft reset
        bus_write(5'h04, 8'h5A);
        bus_write(5'h0C, 8'h40);
        bus_write(5'h14, 8'h03);
        expect_read(5'h18, 8'h00, "R9 reset done low");
        expect_read(5'h14, 8'h02, "R9 reset bit visible");
        repeat (P_RST + 2) @(negedge clk);
        expect_read(5'h18, 8'h01, "R9 reset done high");
        expect_read(5'h04, 8'h00, "R9 tx data default");
        expect_read(5'h0C, 8'h00, "R9 control default");
        expect_read(5'h14, 8'h00, "R9 config default");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2/R3 all expected pulses seen", exp_q.size(), 0);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule